// File: doc/BRIEF.md
# I2S Audio Serial Transmitter

This block takes audio words from a sample store beside it and shifts them out on a single I2S data line, most significant bit first. Left-channel and right-channel words alternate. At build time a parameter makes it a clock master or a clock slave. As master it makes the serial bit clock and the channel-select line itself, using a divider that is set at run time. As slave it receives both lines from outside, passes them through synchronizers into the system clock domain and acts on their edges.

Words are fetched with a single-cycle read strobe and an address. The address's low bit gives the channel slot, and its upper bits count left/right pairs. The store must present the word one cycle after the strobe and hold it there. Four inputs apply at run time: the number of bits sent per word, the divider ratio, the choice of which address parity goes to the left channel, and an enable.

Top module: `i2s_tx`

## Requirements
- R1: The effective resolution is `res_i` when 8 <= `res_i` <= 32 and `res_i` <= DATA_WIDTH, and 8 for any other value. Only the lowest resolution bits of each fetched word are sent, MSB first, and the bits above them have no effect on `sd_o`.
- R2: In master mode `sck_o` is low after enable and has a period of exactly 2*(`ratio_i`+2) system clock cycles. Its first edge after enable is a rising edge.
- R3: In master mode `ws_o` is low (left) for the first word after enable. It toggles on a falling edge of `sck_o` once every resolution-many `sck_o` periods, so each word carries exactly resolution bits.
- R4: `sd_o` changes only together with a falling edge of the serial clock. The MSB of a word appears one serial-clock period after the channel-select transition, and the LSB of the previous word occupies the bit period in which channel select already shows the new channel.
- R5: `rd_o` is a one-cycle pulse, issued once per word. The word must be on `rd_data_i` from the cycle after the pulse until the next pulse.
- R6: Each read uses `addr_o` = {pair index, channel XOR `swap_i`}, where channel is 0 for left and 1 for right. The pair index starts at 0 on enable and advances after each right-channel read. With `swap_i`=0, even addresses go to the left channel; with `swap_i`=1, odd addresses do.
- R7: While `en_i` is low, `sd_o`, `rd_o`, `sck_o` and `ws_o` are low. After reset and after each re-enable, transfer restarts at pair 0 on the left channel.
- R8: In slave mode `sck_i` and `ws_i` pass through two-flop synchronizers, `sck_o` and `ws_o` stay low, and words follow the transitions of `ws_i`. When a `ws_i` half-frame is longer than the resolution, the extra bits are 0.
- R9: In master mode `sck_i` and `ws_i` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| res_i | input | 6 | Requested bits per word |
| ratio_i | input | 8 | Divider ratio for master bit clock |
| swap_i | input | 1 | 1: odd addresses feed the left channel |
| rd_data_i | input | DATA_WIDTH | Word from the sample store, valid the cycle after `rd_o` |
| sck_i | input | 1 | External bit clock (slave mode) |
| ws_i | input | 1 | External channel select (slave mode) |
| rd_o | output | 1 | Read strobe to the sample store |
| addr_o | output | ADDR_WIDTH | Read address |
| sd_o | output | 1 | Serial data |
| sck_o | output | 1 | Bit clock (master mode, else low) |
| ws_o | output | 1 | Channel select, 1 = right (master mode, else low) |

## Verification
The assertions assume that resolution, ratio and swap are changed only while `en_i` is low. In slave mode they assume that `ws_i` changes only together with a falling `sck_i`, and that each `sck_i` level lasts at least three system clocks, which leaves time for the fetch to finish between a rising and a falling edge. The stimulus therefore changes configuration only in disabled gaps between runs. The external slave clock it drives has a half period of six system clocks, and it toggles channel select only at its own falling edges. Meanwhile the master instance gets random toggling on its unused clock inputs.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int unsigned RES_W   = 6;
  localparam int unsigned RATIO_W = 8;
  localparam int unsigned RES_MIN = 8;
  localparam int unsigned RES_MAX = 32;

  function automatic logic [RES_W-1:0] clamp_res(input logic [RES_W-1:0] res,
                                                 input int unsigned dw);
    int unsigned r;
    r = 32'(res);
    if (r >= RES_MIN && r <= RES_MAX && r <= dw) return res;
    return RES_W'(RES_MIN);
  endfunction
endpackage

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen
  import i2s_tx_pkg::*;
#(
  parameter bit MASTER = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [RES_W-1:0]   res_i,
  input  logic               sck_i,
  input  logic               ws_i,
  output logic               rise_o,
  output logic               fall_o,
  output logic               ws_lvl_o,
  output logic               sck_o,
  output logic               ws_o
);

  if (MASTER) begin : g_master
    localparam int unsigned DIV_W = RATIO_W + 1;
    logic [DIV_W-1:0] div_q, lim;
    logic             sck_q, ws_q, tick;
    logic [RES_W-1:0] bit_q;
    logic             unused_pins;

    assign unused_pins = sck_i ^ ws_i;
    assign lim  = {1'b0, ratio_i} + DIV_W'(1);
    assign tick = en_i && (div_q == lim);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        div_q <= '0;
        sck_q <= 1'b0;
        ws_q  <= 1'b0;
        bit_q <= '0;
      end else if (!en_i) begin
        div_q <= '0;
        sck_q <= 1'b0;
        ws_q  <= 1'b0;
        bit_q <= '0;
      end else if (tick) begin
        div_q <= '0;
        sck_q <= ~sck_q;
        if (sck_q) begin
          // word boundary: ws moves with the LSB bit period
          if (bit_q == res_i - RES_W'(1)) begin
            bit_q <= '0;
            ws_q  <= ~ws_q;
          end else begin
            bit_q <= bit_q + RES_W'(1);
          end
        end
      end else begin
        div_q <= div_q + DIV_W'(1);
      end
    end

    assign rise_o   = tick & ~sck_q;
    assign fall_o   = tick & sck_q;
    assign ws_lvl_o = ws_q;
    assign sck_o    = sck_q;
    assign ws_o     = ws_q;

    // R3
    bit_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && $past(en_i) && $stable(res_i)) |-> (bit_q < res_i));

    // R2
    div_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && $past(en_i) && $stable(ratio_i)) |-> (div_q <= lim));

    // R7
    master_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (!sck_q && !ws_q));

  end else begin : g_slave
    logic [2:0] sck_s;
    logic [1:0] ws_s;
    logic       unused_cfg;

    assign unused_cfg = ^{ratio_i, res_i};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sck_s <= '0;
        ws_s  <= '0;
      end else begin
        sck_s <= {sck_s[1:0], sck_i};
        ws_s  <= {ws_s[0], ws_i};
      end
    end

    assign rise_o   = en_i & sck_s[1] & ~sck_s[2];
    assign fall_o   = en_i & ~sck_s[1] & sck_s[2];
    assign ws_lvl_o = ws_s[1];
    assign sck_o    = 1'b0;
    assign ws_o     = 1'b0;
  end

endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter
  import i2s_tx_pkg::*;
#(
  parameter int unsigned DATA_WIDTH = 32,
  parameter int unsigned ADDR_WIDTH = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [RES_W-1:0]      res_i,
  input  logic                  swap_i,
  input  logic                  rise_i,
  input  logic                  fall_i,
  input  logic                  ws_i,
  input  logic [DATA_WIDTH-1:0] rd_data_i,
  output logic                  rd_o,
  output logic [ADDR_WIDTH-1:0] addr_o,
  output logic                  sd_o
);
  localparam int unsigned PAIR_W = ADDR_WIDTH - 1;

  logic                  ws_r_q, pend_q, rd_q, rd_d_q, new_word;
  logic [PAIR_W-1:0]     pair_q;
  logic [ADDR_WIDTH-1:0] addr_q;
  logic [DATA_WIDTH-1:0] hold_q, sh_q, src, aligned;
  logic [RES_W-1:0]      shamt;

  // ws seen at a rising edge differs from the last one: next fall carries a MSB
  assign new_word = rise_i && (ws_i != ws_r_q);
  assign src      = rd_d_q ? rd_data_i : hold_q;
  assign shamt    = RES_W'(DATA_WIDTH) - res_i;
  assign aligned  = src << shamt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_r_q <= 1'b1;
      pend_q <= 1'b0;
      rd_q   <= 1'b0;
      rd_d_q <= 1'b0;
      pair_q <= '0;
      addr_q <= '0;
      hold_q <= '0;
      sh_q   <= '0;
    end else if (!en_i) begin
      ws_r_q <= 1'b1;
      pend_q <= 1'b0;
      rd_q   <= 1'b0;
      rd_d_q <= 1'b0;
      pair_q <= '0;
      addr_q <= '0;
      sh_q   <= '0;
    end else begin
      rd_q   <= new_word;
      rd_d_q <= rd_q;
      if (rise_i) ws_r_q <= ws_i;
      if (new_word) begin
        addr_q <= {pair_q, ws_i ^ swap_i};
        if (ws_i) pair_q <= pair_q + PAIR_W'(1);
        pend_q <= 1'b1;
      end
      if (rd_d_q) hold_q <= rd_data_i;
      if (fall_i) begin
        if (pend_q) begin
          sh_q   <= aligned;
          pend_q <= 1'b0;
        end else begin
          sh_q <= {sh_q[DATA_WIDTH-2:0], 1'b0};
        end
      end
    end
  end

  assign rd_o   = rd_q;
  assign addr_o = addr_q;
  assign sd_o   = sh_q[DATA_WIDTH-1];

  logic seen_q, last_par_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q     <= 1'b0;
      last_par_q <= 1'b0;
    end else if (!en_i) begin
      seen_q <= 1'b0;
    end else if (rd_q) begin
      seen_q     <= 1'b1;
      last_par_q <= addr_q[0];
    end
  end

  // R5
  rd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q |=> !rd_q);

  // R7
  idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sd_o && !rd_o));

  // R6
  par_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_q && seen_q) |-> (addr_q[0] != last_par_q));

  // R4
  sh_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sh_q) |-> ($past(fall_i) || !$past(en_i)));

  // R4
  edge_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_i && fall_i));

endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
  import i2s_tx_pkg::*;
#(
  parameter int unsigned DATA_WIDTH = 32,
  parameter int unsigned ADDR_WIDTH = 8,
  parameter bit          MASTER     = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [RES_W-1:0]      res_i,
  input  logic [RATIO_W-1:0]    ratio_i,
  input  logic                  swap_i,
  input  logic [DATA_WIDTH-1:0] rd_data_i,
  input  logic                  sck_i,
  input  logic                  ws_i,
  output logic                  rd_o,
  output logic [ADDR_WIDTH-1:0] addr_o,
  output logic                  sd_o,
  output logic                  sck_o,
  output logic                  ws_o
);
  logic [RES_W-1:0] res_eff;
  logic             rise, fall, ws_lvl;

  assign res_eff = clamp_res(res_i, DATA_WIDTH);

  i2s_tx_clkgen #(.MASTER(MASTER)) i_clkgen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .ratio_i (ratio_i),
    .res_i   (res_eff),
    .sck_i   (sck_i),
    .ws_i    (ws_i),
    .rise_o  (rise),
    .fall_o  (fall),
    .ws_lvl_o(ws_lvl),
    .sck_o   (sck_o),
    .ws_o    (ws_o)
  );

  i2s_tx_shifter #(.DATA_WIDTH(DATA_WIDTH), .ADDR_WIDTH(ADDR_WIDTH)) i_shifter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .res_i    (res_eff),
    .swap_i   (swap_i),
    .rise_i   (rise),
    .fall_i   (fall),
    .ws_i     (ws_lvl),
    .rd_data_i(rd_data_i),
    .rd_o     (rd_o),
    .addr_o   (addr_o),
    .sd_o     (sd_o)
  );

endmodule

// File: tb/test_i2s_tx.sv
module test_i2s_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_m = 1'b0, en_s = 1'b0;
  logic [5:0]  res = 6'd16;
  logic [7:0]  ratio = 8'd0;
  logic        swap = 1'b0;
  logic [31:0] salt = 32'h0;
  logic [31:0] rdata_m = '0, rdata_s = '0;
  logic        rd_m, rd_s, sd_m, sd_s, sck_m, ws_m, sck_so, ws_so;
  logic [7:0]  addr_m, addr_s;
  logic        junk_sck = 1'b0, junk_ws = 1'b0;
  logic        ext_sck = 1'b0, ext_ws = 1'b0;
  int          total = 0, fails = 0, cyc_all = 0;

  always #4 clk = ~clk;

  i2s_tx #(.DATA_WIDTH(32), .ADDR_WIDTH(8), .MASTER(1'b1)) i_i2s_tx (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_m), .res_i(res), .ratio_i(ratio),
    .swap_i(swap), .rd_data_i(rdata_m), .sck_i(junk_sck), .ws_i(junk_ws),
    .rd_o(rd_m), .addr_o(addr_m), .sd_o(sd_m), .sck_o(sck_m), .ws_o(ws_m));

  i2s_tx #(.DATA_WIDTH(32), .ADDR_WIDTH(8), .MASTER(1'b0)) i_i2s_tx_slv (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_s), .res_i(res), .ratio_i(ratio),
    .swap_i(swap), .rd_data_i(rdata_s), .sck_i(ext_sck), .ws_i(ext_ws),
    .rd_o(rd_s), .addr_o(addr_s), .sd_o(sd_s), .sck_o(sck_so), .ws_o(ws_so));

  function automatic logic [31:0] mem_word(input logic [7:0] a);
    return (32'(a) * 32'h9E37_79B1) ^ salt;
  endfunction

  function automatic int exp_res(input logic [5:0] r);
    return (r >= 6'd8 && r <= 6'd32) ? int'(r) : 8;
  endfunction

  function automatic longint lowmask(input int n);
    return (longint'(1) << n) - 1;
  endfunction

  // sample store: word valid the cycle after the strobe, then held
  always @(posedge clk) begin
    if (rd_m) rdata_m <= mem_word(addr_m);
    if (rd_s) rdata_s <= mem_word(addr_s);
  end

  always @(negedge clk) begin
    junk_sck <= 1'($urandom());
    junk_ws  <= 1'($urandom());
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp_v);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc_all++;
    if (cyc_all > 180000) begin
      check(1'b0, "watchdog expired", cyc_all, 180000);
      finish_run();
    end
  end

  task automatic run_master(input logic [5:0] r, input logic [7:0] q, input bit sw, input int nwords);
    int eff, k, n, periods, last_rise, cyc, rdcnt, sd_bad, wbad, idle_bad;
    logic prev_sck, prev_ws, prev_sd, first;
    longint acc, expv;
    logic [7:0] a;
    @(negedge clk);
    res = r; ratio = q; swap = sw; salt = $urandom();
    en_m = 1'b1;
    eff = exp_res(r);
    k = 0; n = 0; periods = 0; last_rise = -1; cyc = 0; rdcnt = 0; sd_bad = 0; wbad = 0;
    prev_sck = 1'b0; prev_sd = 1'b0; prev_ws = 1'b0; first = 1'b1; acc = 0;
    while (k < nwords && cyc < 30000) begin
      @(negedge clk);
      cyc++;
      if (rd_m) rdcnt++;
      if (sd_m !== prev_sd && !(prev_sck && !sck_m)) sd_bad++;
      if (sck_m && !prev_sck) begin
        if (last_rise >= 0 && periods < 3) begin
          check(cyc - last_rise == 2 * (int'(q) + 2), "R2 sck period", cyc - last_rise, 2 * (int'(q) + 2));
          periods++;
        end
        last_rise = cyc;
        if (first) begin
          first = 1'b0;
          prev_ws = ws_m;
          check(ws_m == 1'b0, "R3 first word on left", ws_m, 0);
        end else begin
          acc = (acc << 1) | longint'(sd_m);
          n++;
          if (ws_m != prev_ws) begin
            a = 8'(((k / 2) << 1) | (int'(prev_ws) ^ int'(sw)));
            expv = longint'(mem_word(a)) & lowmask(eff);
            check(acc == expv, "R1,R6 word data", acc, expv);
            if (acc != expv) wbad++;
            check(n == eff, "R3 bits per word", n, eff);
            check(prev_ws == 1'(k % 2), "R3 channel order", prev_ws, k % 2);
            k++; acc = 0; n = 0; prev_ws = ws_m;
          end
        end
      end
      prev_sck = sck_m;
      prev_sd = sd_m;
    end
    check(k == nwords, "R2 words completed", k, nwords);
    check(sd_bad == 0, "R4 sd moves only with sck fall", sd_bad, 0);
    check(rdcnt >= nwords && rdcnt <= nwords + 1, "R5 one strobe per word", rdcnt, nwords);
    check(wbad == 0, "R9 master ignores sck_i/ws_i", wbad, 0);
    @(negedge clk);
    en_m = 1'b0;
    idle_bad = 0;
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sd_m || rd_m || sck_m || ws_m) idle_bad++;
    end
    check(idle_bad == 0, "R7 outputs low while disabled", idle_bad, 0);
  endtask

  task automatic run_slave(input logic [5:0] r, input bit sw, input int wbits, input int half, input int nwords);
    int eff, k, n, fc, outbad, guard;
    logic prev_ws, first, s;
    longint acc, expv;
    logic [7:0] a;
    @(negedge clk);
    res = r; swap = sw; salt = $urandom();
    ext_sck = 1'b0; ext_ws = 1'b0;
    en_s = 1'b1;
    repeat (4) @(negedge clk);
    eff = exp_res(r);
    k = 0; n = 0; fc = 0; outbad = 0; guard = 0; first = 1'b1; acc = 0; prev_ws = 1'b0;
    while (k < nwords && guard < 2000) begin
      guard++;
      repeat (half) begin
        @(negedge clk);
        if (sck_so || ws_so) outbad++;
      end
      s = sd_s;
      if (first) begin
        first = 1'b0;
        prev_ws = ext_ws;
      end else begin
        acc = (acc << 1) | longint'(s);
        n++;
        if (ext_ws != prev_ws) begin
          a = 8'(((k / 2) << 1) | (int'(prev_ws) ^ int'(sw)));
          expv = (longint'(mem_word(a)) & lowmask(eff)) << (wbits - eff);
          check(acc == expv, "R8 slave word with zero fill", acc, expv);
          check(n == wbits, "R8 slave bits per half-frame", n, wbits);
          k++; acc = 0; n = 0; prev_ws = ext_ws;
        end
      end
      ext_sck = 1'b1;
      repeat (half) begin
        @(negedge clk);
        if (sck_so || ws_so) outbad++;
      end
      ext_sck = 1'b0;
      if (fc == wbits - 1) begin
        ext_ws = ~ext_ws;
        fc = 0;
      end else begin
        fc++;
      end
    end
    check(k == nwords, "R8 slave words completed", k, nwords);
    check(outbad == 0, "R8 slave sck_o/ws_o low", outbad, 0);
    @(negedge clk);
    en_s = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!sd_m && !rd_m && !sck_m && !ws_m, "R7 master reset state",
          {sd_m, rd_m, sck_m, ws_m}, 0);
    check(!sd_s && !rd_s && !sck_so && !ws_so, "R7 slave reset state",
          {sd_s, rd_s, sck_so, ws_so}, 0);

    run_master(6'd16, 8'd0, 1'b0, 6);
    run_master(6'd24, 8'd3, 1'b1, 6);
    run_master(6'd5,  8'd1, 1'b0, 4);   // R1 below range -> 8
    run_master(6'd45, 8'd0, 1'b1, 4);   // R1 above range -> 8
    run_master(6'd0,  8'd2, 1'b0, 4);   // R1 zero -> 8
    run_master(6'd32, 8'd2, 1'b1, 6);
    run_master(6'd8,  8'd7, 1'b0, 5);
    for (int i = 0; i < 6; i++) begin
      run_master(6'(8 + ($urandom() % 25)), 8'($urandom() % 5), 1'($urandom()), 5);
    end

    run_slave(6'd16, 1'b0, 20, 6, 6);
    run_slave(6'd24, 1'b1, 24, 6, 6);
    run_slave(6'd3,  1'b0, 10, 6, 4);
    run_slave(6'(8 + ($urandom() % 17)), 1'($urandom()), 26, 6, 4);

    finish_run();
  end
endmodule